// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo PCM bit stream into parallel samples. It runs directly in the bit-clock domain. On every rising bit-clock edge it samples the word-select line and the data line. Each channel's sample comes out as a 24-bit two's complement word with a one-cycle valid strobe. The strobe fires when the word-select level changes and so closes that channel's slot.

A 3-bit format code selects how a sample sits inside its slot:

| Code | Framing | Bits used |
|------|---------|-----------|
| 0 | Left-justified | up to 24 |
| 1 | I2S-style, delayed one bit | up to 24 |
| 2 | Right-justified | 16 |
| 3 | Right-justified | 24 |
| 4 | Right-justified | 20 |
| 5 | Right-justified | 18 |

A control-port enable input decides how many codes are reachable. When it is low, the block is in stand-alone mode and the top bit of the code is ignored, so only codes 0 to 3 can be chosen. A single shift engine serves every framing. Right-justified words are taken from the bits that arrived just before the word-select edge, so the slot length never has to be known.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held low, both data outputs read zero and both strobes are low.
- R2: Format 0, left-justified: word-select high marks the left slot. The first bit sampled after a word-select change is the MSB, and up to 24 bits are taken from there.
- R3: Format 1, I2S-style: word-select low marks the left slot. The MSB is the second bit sampled after a word-select change.
- R4: Formats 2, 3, 4 and 5 are right-justified with 16, 24, 20 and 18 bits. Word-select high marks the left slot. The LSB is the last bit sampled before the word-select change.
- R5: A word shorter than 24 bits is left-aligned in the output, with zeros in the bits below it. Slot bits beyond bit 24 in formats 0 and 1, and slot bits ahead of the word in the right-justified formats, have no effect on the output.
- R6: A channel's strobe is high for exactly one cycle. It rises at the rising bit-clock edge that first samples the new word-select level, which closes that channel's slot. The two strobes are never high together.
- R7: Each data output holds its value from one strobe of its channel to the next.
- R8: With control-port enable low, the top format bit is ignored, so code 4 acts as code 0 and code 5 acts as code 1.
- R9: A slot that is already in progress when reset is released produces no strobe.
- R10: With control-port enable high, codes 6 and 7 act as left-justified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| ws | input | 1 | Word-select; its level names the active channel |
| sd | input | 1 | Serial data, MSB first |
| fmt | input | 3 | Framing code |
| cp_en | input | 1 | High: all codes reachable; low: stand-alone, top code bit ignored |
| l_data | output | 24 | Last left sample |
| r_data | output | 24 | Last right sample |
| l_vld | output | 1 | One-cycle strobe for a new left sample |
| r_vld | output | 1 | One-cycle strobe for a new right sample |

## Verification
The bench fills every unused slot bit with ones. A design that fails to ignore padding then shows stray ones in the low bits, and one that takes the wrong right-justified window shows shifted data. Short 16-bit slots in formats 0 and 1 catch a design that does not zero-fill, or that mixes up the one-bit I2S delay (it would return 16 bits instead of 15). Each run starts with a partial slot after reset, so a design that arms on the reset value of word-select gives an extra strobe. The cycle of each strobe is compared with the first bit of the next slot, which exposes an extra register stage or an early strobe.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int DW = 24,
  parameter int CW = 8
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          ws,
  input  logic          sd,
  input  logic [2:0]    fmt,
  input  logic          cp_en,
  output logic [DW-1:0] l_data,
  output logic [DW-1:0] r_data,
  output logic          l_vld,
  output logic          r_vld
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          ws_q, started, armed;
  logic [CW-1:0] cnt, idx;
  logic [DW-1:0] acc, acc_n, sh, word;
  logic [2:0]    fmt_eff;
  logic          is_i2s, is_rj, edge_w, close_left;
  int            rj_w;

  assign fmt_eff    = cp_en ? fmt : {1'b0, fmt[1:0]};
  assign is_i2s     = (fmt_eff == 3'd1);
  assign is_rj      = (fmt_eff >= 3'd2) && (fmt_eff <= 3'd5);
  assign edge_w     = started && (ws != ws_q);
  assign close_left = is_i2s ? ~ws_q : ws_q;
  assign idx        = edge_w ? '0 : cnt;

  always_comb begin
    case (fmt_eff)
      3'd2:    rj_w = 16;
      3'd4:    rj_w = 20;
      3'd5:    rj_w = 18;
      default: rj_w = DW;
    endcase
  end

  assign word = is_rj ? (sh << (DW - rj_w)) : acc;

  always_comb begin
    int pos;
    acc_n = edge_w ? '0 : acc;
    pos   = int'(idx) - (is_i2s ? 1 : 0);
    for (int i = 0; i < DW; i++)
      if (pos == DW - 1 - i) acc_n[i] = sd;
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q    <= 1'b0;
      started <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
      acc     <= '0;
      sh      <= '0;
      l_data  <= '0;
      r_data  <= '0;
      l_vld   <= 1'b0;
      r_vld   <= 1'b0;
    end else begin
      ws_q    <= ws;
      started <= 1'b1;
      armed   <= armed | edge_w;
      cnt     <= (idx == CMAX) ? idx : idx + 1'b1;
      acc     <= acc_n;
      sh      <= {sh[DW-2:0], sd};
      l_vld   <= edge_w && armed && close_left;
      r_vld   <= edge_w && armed && !close_left;
      if (edge_w && armed && close_left)  l_data <= word;
      if (edge_w && armed && !close_left) r_data <= word;
    end
  end

  AST_NO_DUAL_STROBE: assert property (@(posedge bclk) disable iff (!rst_n)
    !(l_vld && r_vld)); // R6
  AST_LVLD_ON_WS_EDGE: assert property (@(posedge bclk) disable iff (!rst_n)
    l_vld |-> (ws_q != $past(ws_q))); // R6
  AST_RVLD_ON_WS_EDGE: assert property (@(posedge bclk) disable iff (!rst_n)
    r_vld |-> (ws_q != $past(ws_q))); // R6
  AST_L_HELD: assert property (@(posedge bclk) disable iff (!rst_n)
    !l_vld |-> $stable(l_data)); // R7
  AST_R_HELD: assert property (@(posedge bclk) disable iff (!rst_n)
    !r_vld |-> $stable(r_data)); // R7
endmodule

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  localparam int PER = 10;

  logic        bclk = 1'b0, rst_n = 1'b0, ws = 1'b0, sd = 1'b0, cp_en = 1'b1;
  logic [2:0]  fmt = 3'd0;
  logic [23:0] l_data, r_data;
  logic        l_vld, r_vld;

  int n_run = 0, n_fail = 0;
  int slot_pos = 0;
  int nl = 0, nr = 0, ndual = 0, lpos = -1, rpos = -1;
  logic [23:0] ld, rd;

  serial_audio_rx u0 (.bclk(bclk), .rst_n(rst_n), .ws(ws), .sd(sd), .fmt(fmt),
                      .cp_en(cp_en), .l_data(l_data), .r_data(r_data),
                      .l_vld(l_vld), .r_vld(r_vld));

  always #(PER/2) bclk = ~bclk;

  always @(posedge bclk) begin
    #1;
    if (l_vld) begin nl++; ld = l_data; lpos = slot_pos; end
    if (r_vld) begin nr++; rd = r_data; rpos = slot_pos; end
    if (l_vld && r_vld) ndual++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic gen_bit(int kind, int n, int s, int p, logic [23:0] v);
    int q;
    if (kind == 0) return (p < 24) ? v[23-p] : 1'b1;
    if (kind == 1) begin
      q = p - 1;
      return (p >= 1 && q < 24) ? v[23-q] : 1'b1;
    end
    q = p - (s - n);
    return (q >= 0) ? v[23-q] : 1'b1;
  endfunction

  function automatic logic [23:0] exp_val(int kind, int n, int s, logic [23:0] v);
    int k;
    if (kind == 0) k = (s < 24) ? s : 24;
    else if (kind == 1) k = (s - 1 < 24) ? s - 1 : 24;
    else k = n;
    return v & (24'hFFFFFF << (24 - k));
  endfunction

  task automatic drive_bit(input logic w, input logic b, input int pos);
    @(negedge bclk);
    ws = w; sd = b; slot_pos = pos;
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge bclk);
    rst_n = 1'b0; ws = lvl; sd = 1'b0;
    repeat (3) @(negedge bclk);
    rst_n = 1'b1;
    nl = 0; nr = 0; ndual = 0; lpos = -1; rpos = -1;
  endtask

  task automatic test_reset();
    @(negedge bclk);
    rst_n = 1'b0;
    repeat (2) @(posedge bclk);
    #1;
    chk(l_data == 0 && r_data == 0, "R1", "data in reset", {l_data, r_data}, 0);
    chk(!l_vld && !r_vld, "R1", "strobes in reset", {l_vld, r_vld}, 0);
  endtask

  task automatic run_case(input string req, input logic [2:0] f, input logic cp,
                          input int kind, input int n, input int s,
                          input logic [23:0] lv, input logic [23:0] rv);
    logic ll;
    logic [23:0] el, er;
    ll = (kind == 1) ? 1'b0 : 1'b1;
    fmt = f; cp_en = cp;
    do_reset(~ll);
    for (int p = 0; p < 5; p++) drive_bit(~ll, 1'b1, p + 40);
    for (int p = 0; p < s; p++) drive_bit(ll, gen_bit(kind, n, s, p, lv), p);
    for (int p = 0; p < s; p++) drive_bit(~ll, gen_bit(kind, n, s, p, rv), p);
    for (int p = 0; p < 4; p++) drive_bit(ll, 1'b1, p);
    @(posedge bclk); #2;
    el = exp_val(kind, n, s, lv);
    er = exp_val(kind, n, s, rv);
    chk(ld == el, req, "left word", ld, el);
    chk(rd == er, req, "right word", rd, er);
    chk(nl == 1, "R6", "left strobe count", nl, 1);
    chk(nr == 1, "R9", "right strobe count incl. partial slot", nr, 1);
    chk(lpos == 0 && rpos == 0, "R6", "strobe cycle", {lpos[15:0], rpos[15:0]}, 0);
    chk(ndual == 0, "R6", "simultaneous strobes", ndual, 0);
    chk(l_data == el && r_data == er, "R7", "held data", l_data, el);
  endtask

  initial begin
    #(PER * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    run_case("R2", 3'd0, 1'b1, 0, 24, 32, 24'hA5C3_91, 24'h3C_5A_7E);
    run_case("R3", 3'd1, 1'b1, 1, 24, 32, 24'h96_1E_D4, 24'h5B_72_0F);
    run_case("R5", 3'd0, 1'b1, 0, 24, 16, 24'hC3_81_FF, 24'h7E_11_FF);
    run_case("R5", 3'd1, 1'b1, 1, 24, 16, 24'hD5_A3_FF, 24'h29_6C_FF);
    run_case("R2", 3'd0, 1'b1, 0, 24, 64, 24'h81_42_24, 24'hFF_00_01);
    run_case("R4", 3'd2, 1'b1, 2, 16, 32, 24'hB7_4D_00, 24'h40_01_00);
    run_case("R4", 3'd3, 1'b1, 2, 24, 32, 24'h80_00_01, 24'h7F_FF_FE);
    run_case("R4", 3'd4, 1'b1, 2, 20, 48, 24'hE1_D2_C0, 24'h12_34_50);
    run_case("R4", 3'd5, 1'b1, 2, 18, 32, 24'h9A_BC_C0, 24'h65_43_40);
    run_case("R8", 3'd4, 1'b0, 0, 24, 32, 24'h0F_F0_5A, 24'hF0_0F_A5);
    run_case("R8", 3'd5, 1'b0, 1, 24, 32, 24'h71_8E_33, 24'h8E_71_CC);
    run_case("R10", 3'd6, 1'b1, 0, 24, 32, 24'h44_88_CC, 24'hBB_77_33);
    run_case("R10", 3'd7, 1'b1, 0, 24, 32, 24'h13_57_9B, 24'hEC_A8_64);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule